// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit up-counter that drives two waveform outputs from a shared, prescaled count. It runs in three settings. In clear-on-match, channel A's compare value sets the counter's ceiling. In single-slope PWM, the ceiling is either fixed at 255 or taken from channel A's compare value. The counter advances once per prescaler tick. The prescaler is a free-running divider with seven divide ratios plus a stop setting.

Each channel has a compare value, a 2-bit action field and an enable bit that gates it onto its pin. On a match, the action field can toggle the output, clear it or set it. In the PWM settings the opposite level is restored when the counter wraps to zero, which gives non-inverted or inverted pulse trains. Three sticky flags report wraps through 255 and compare matches. Software sets up the block through a small address/data write port and reads it back on the same address.

In the clear-on-match setting the ceiling is used unbuffered. A ceiling written below the current count is therefore missed, and the counter runs on through 255 before it can match. In the PWM settings the compare values are buffered and take effect at the wrap. A match is suppressed for one tick after software writes the counter.

Top module: `wave_timer8`

## Requirements
- R1: After reset, every register reads 0, including the counter and the flags, and both waveform pins are low.
- R2: Clock select `ctl[2:0]` sets the divide ratio: 1→1, 2→8, 3→32, 4→64, 5→128, 6→256, 7→1024. Setting 0 stops the counter. The counter rises by one per tick. Mode codes other than 2, 3 and 7 count freely from 0 to 255 and wrap.
- R3: In mode code 2 (`ctl[5:3]`), the counter returns to 0 on the tick after it equals compare A. A write to compare A takes effect at once.
- R4: In mode 2, if compare A is written below the current count, no match occurs until the counter has passed 255 and wrapped to 0.
- R5: Action code 1 inverts the output on every match. With mode 2, compare A = 0 and divide 1, pin A toggles on every clock.
- R6: Mode 3 is PWM with a ceiling of 255. Mode 7 is PWM with the ceiling equal to compare A. After reaching the ceiling, the counter clears on the next tick.
- R7: In PWM modes, action code 2 drives the output low on a match and high at the wrap. Action code 3 does the reverse. A compare value equal to the ceiling gives an output that stays high under code 2.
- R8: In PWM modes, compare writes go to a holding register and become active at the wrap.
- R9: Overflow flag (`flags[0]`) sets when the counter passes from 255 to 0. In PWM modes it also sets at the wrap from the ceiling.
- R10: Flags `flags[0]`, `flags[1]` (match A) and `flags[2]` (match B) stay set until software writes 1 to that bit. Writing 0 leaves them unchanged.
- R11: A pin is low whenever its enable bit is clear or its action code is 0.
- R12: After a software write to the counter, the next tick produces no compare match.
- R13: The register map is: address 0 `ctl` (clock select `[2:0]`, mode `[5:3]`); address 1 `ocfg` (action A `[1:0]`, action B `[3:2]`, enable A `[4]`, enable B `[5]`); address 2 compare A; address 3 compare B; address 4 counter; address 5 flags. A read of a compare address returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmpa_flag | output | 1 | Sticky compare A flag |
| cmpb_flag | output | 1 | Sticky compare B flag |

## Verification
The clocked properties assume that no register write lands in the same cycle as the event they check. Each antecedent therefore excludes a write strobe or a counter write, and the checks cover only ticks where configuration and count are left alone.

The stimulus keeps to this in two ways. It changes configuration mostly while the clock select is 0. It then waits well over one full counter period before measuring duty, toggle rate or flags, so every buffered compare value has been loaded. Duty is counted over a window of exactly one period, so the result does not depend on the counter's phase.

// File: rtl/wave_timer8.sv
module wave_timer8 #(
  parameter int CW = 8,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          wave_a,
  output logic          wave_b,
  output logic          ovf_flag,
  output logic          cmpa_flag,
  output logic          cmpb_flag
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [5:0]    ctrl_r, ocfg_r;
  logic [CW-1:0] ocra_buf, ocrb_buf, ocra_act, ocrb_act, cnt;
  logic [PW-1:0] pre_cnt, mask;
  logic          blk, out_a, out_b;

  wire [2:0] clk_sel = ctrl_r[2:0];
  wire [2:0] mode    = ctrl_r[5:3];
  wire       pwm     = (mode == 3'd3) || (mode == 3'd7);
  wire [CW-1:0] top  = (mode == 3'd2 || mode == 3'd7) ? ocra_act : MAXV;

  always_comb begin
    case (clk_sel)
      3'd2:    mask = PW'(7);
      3'd3:    mask = PW'(31);
      3'd4:    mask = PW'(63);
      3'd5:    mask = PW'(127);
      3'd6:    mask = PW'(255);
      3'd7:    mask = PW'(1023);
      default: mask = '0;
    endcase
  end

  wire tick   = (clk_sel != 3'd0) && ((pre_cnt & mask) == mask);
  wire cnt_wr = wr_en && addr == 3'd4;
  wire wrap   = tick && cnt == top;
  wire hit_a  = tick && !blk && cnt == ocra_act;
  wire hit_b  = tick && !blk && cnt == ocrb_act;
  wire ovf_set = tick && (cnt == MAXV || (pwm && cnt == top));
  wire fl_wr  = wr_en && addr == 3'd5;

  function automatic logic next_wave(input logic cur, input logic [1:0] com,
                                     input logic is_pwm, input logic hit, input logic bot);
    case (com)
      2'd1:    return hit ? ~cur : cur;
      2'd2:    return (is_pwm && bot) ? 1'b1 : (hit ? 1'b0 : cur);
      2'd3:    return (is_pwm && bot) ? 1'b0 : (hit ? 1'b1 : cur);
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r    <= '0;
      ocfg_r    <= '0;
      ocra_buf  <= '0;
      ocrb_buf  <= '0;
      ocra_act  <= '0;
      ocrb_act  <= '0;
      cnt       <= '0;
      pre_cnt   <= '0;
      blk       <= 1'b0;
      out_a     <= 1'b0;
      out_b     <= 1'b0;
      ovf_flag  <= 1'b0;
      cmpa_flag <= 1'b0;
      cmpb_flag <= 1'b0;
    end else begin
      pre_cnt <= (clk_sel == 3'd0) ? '0 : pre_cnt + 1'b1;

      if (wr_en && addr == 3'd0) ctrl_r <= wr_data[5:0];
      if (wr_en && addr == 3'd1) ocfg_r <= wr_data[5:0];
      if (wr_en && addr == 3'd2) ocra_buf <= wr_data;
      if (wr_en && addr == 3'd3) ocrb_buf <= wr_data;

      if (pwm) begin
        if (wrap) begin
          ocra_act <= ocra_buf;
          ocrb_act <= ocrb_buf;
        end
      end else begin
        ocra_act <= (wr_en && addr == 3'd2) ? wr_data : ocra_buf;
        ocrb_act <= (wr_en && addr == 3'd3) ? wr_data : ocrb_buf;
      end

      if (cnt_wr) cnt <= wr_data;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;

      if (cnt_wr) blk <= 1'b1;
      else if (tick) blk <= 1'b0;

      out_a <= next_wave(out_a, ocfg_r[1:0], pwm, hit_a, wrap);
      out_b <= next_wave(out_b, ocfg_r[3:2], pwm, hit_b, wrap);

      ovf_flag  <= ovf_set | (ovf_flag  & ~(fl_wr & wr_data[0]));
      cmpa_flag <= hit_a   | (cmpa_flag & ~(fl_wr & wr_data[1]));
      cmpb_flag <= hit_b   | (cmpb_flag & ~(fl_wr & wr_data[2]));
    end
  end

  assign wave_a = out_a & ocfg_r[4] & (ocfg_r[1:0] != 2'd0);
  assign wave_b = out_b & ocfg_r[5] & (ocfg_r[3:2] != 2'd0);

  always_comb begin
    case (addr)
      3'd0:    rd_data = {{(CW-6){1'b0}}, ctrl_r};
      3'd1:    rd_data = {{(CW-6){1'b0}}, ocfg_r};
      3'd2:    rd_data = ocra_buf;
      3'd3:    rd_data = ocrb_buf;
      3'd4:    rd_data = cnt;
      3'd5:    rd_data = {{(CW-3){1'b0}}, cmpb_flag, cmpa_flag, ovf_flag};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wave_timer8_chk.sv
module wave_timer8_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          clr_a,
  input logic          tick,
  input logic          blk,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt,
  input logic [2:0]    mode,
  input logic [CW-1:0] ocra_act,
  input logic [5:0]    ocfg,
  input logic          wave_a,
  input logic          wave_b,
  input logic          ovf_flag,
  input logic          cmpa_flag
);
  localparam logic [CW-1:0] MAXV = '1;

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R2

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && mode == 3'd2 && cnt == ocra_act) |=> (cnt == '0)); // R3

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == MAXV) |=> ovf_flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_flag && !clr_a) |=> cmpa_flag); // R10

  AST_PWM_SET_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && tick && !wr_en && cnt == MAXV && ocfg[3:2] == 2'd2 && ocfg[5]) |=> wave_b); // R7

  AST_CTC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && tick && !blk && !wr_en && cnt == ocra_act && ocfg[1:0] == 2'd1 && ocfg[4])
      |=> (wave_a != $past(wave_a))); // R5
endmodule

bind wave_timer8 wave_timer8_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .clr_a(wr_en && addr == 3'd5 && wr_data[1]),
  .tick(tick), .blk(blk), .cnt_wr(cnt_wr), .cnt(cnt), .mode(mode),
  .ocra_act(ocra_act), .ocfg(ocfg_r), .wave_a(wave_a), .wave_b(wave_b),
  .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag)
);

// File: tb/wave_timer8_tb_top.sv
module wave_timer8_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wave_a, wave_b, ovf_flag, cmpa_flag, cmpb_flag;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .wave_a(wave_a), .wave_b(wave_b),
    .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_b(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (wave_b) h++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg%0d after reset", a), v, 0);
    end
    check("R1 pins low after reset", {wave_a, wave_b}, 0);
  endtask

  task automatic t_prescale();
    logic [7:0] c0, c1;
    wr(0, 8'h00); wr(4, 8'h00); wr(0, 8'h02);
    rd(4, c0); idle(63); rd(4, c1);
    check("R2 divide-8 step over 64 clocks", 8'(c1 - c0), 8);
    wr(0, 8'h07);
    rd(4, c0); idle(2047); rd(4, c1);
    check("R2 divide-1024 step over 2048 clocks", 8'(c1 - c0), 2);
    wr(0, 8'h00);
    rd(4, c0); idle(50); rd(4, c1);
    check("R2 stopped counter holds", c1, c0);
    rd(0, c0);
    check("R13 ctl readback", c0, 0);
  endtask

  task automatic t_ctc_toggle();
    logic prev;
    int tr;
    wr(0, 8'h00); wr(4, 8'h00); wr(1, 8'h11); wr(2, 8'h00); wr(0, 8'h11);
    idle(300);
    prev = wave_a;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R5 toggle every clock at compare 0", wave_a, !prev);
      prev = wave_a;
    end
    wr(2, 8'h03);
    idle(300);
    tr = 0; prev = wave_a;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (wave_a != prev) tr++;
      prev = wave_a;
    end
    check("R3 R5 four toggles in 16 clocks at compare 3", tr, 4);
  endtask

  task automatic t_missed();
    logic [7:0] v;
    wr(0, 8'h00); wr(2, 8'd200); wr(4, 8'd100); wr(0, 8'h11);
    wr(2, 8'd50); wr(5, 8'h07);
    idle(100);
    rd(5, v);
    check("R4 no match or wrap before 255", v[1:0], 0);
    idle(200);
    rd(5, v);
    check("R4 R9 match and wrap after passing 255", v[1:0], 3);
    rd(4, v);
    check_range("R3 counter bounded by compare A", v, 0, 50);
  endtask

  task automatic t_pwm_fixed();
    logic [7:0] v;
    int h;
    wr(0, 8'h00); wr(3, 8'd63); wr(1, 8'h28); wr(0, 8'h19);
    idle(300);
    high_b(256, h);
    check("R6 R7 non-inverting duty at compare 63", h, 64);
    rd(5, v);
    check("R9 overflow flag in mode 3", v[0], 1);
    wr(1, 8'h2C); idle(300);
    high_b(256, h);
    check("R7 inverting duty at compare 63", h, 192);
    wr(1, 8'h28); wr(3, 8'd255); idle(300);
    high_b(256, h);
    check("R7 compare at ceiling stays high", h, 256);
    wr(1, 8'h08); idle(10);
    high_b(256, h);
    check("R11 enable clear holds pin low", h, 0);
    wr(1, 8'h20); idle(10);
    high_b(256, h);
    check("R11 action code 0 holds pin low", h, 0);
  endtask

  task automatic t_pwm_top_a();
    logic [7:0] v;
    int h;
    wr(0, 8'h10); wr(2, 8'd99); wr(3, 8'd24); wr(1, 8'h28); wr(0, 8'h39);
    idle(250);
    high_b(100, h);
    check("R6 mode 7 duty with ceiling 99", h, 25);
    wr(4, 8'd10); wr(2, 8'd5);
    idle(20);
    rd(4, v);
    check_range("R8 new ceiling not yet active", v, 11, 99);
    rd(2, v);
    check("R13 compare A readback", v, 5);
    idle(250);
    rd(4, v);
    check_range("R8 new ceiling active after wrap", v, 0, 5);
  endtask

  task automatic t_block();
    logic [7:0] v;
    wr(0, 8'h00); wr(5, 8'h07); wr(3, 8'd40); wr(4, 8'd40); wr(0, 8'h01);
    idle(5);
    rd(5, v);
    check("R12 no match on tick after counter write", v[2], 0);
    idle(300);
    rd(5, v);
    check("R12 match on later pass", v[2], 1);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    wr(0, 8'h00);
    wr(5, 8'h00);
    rd(5, v);
    check("R10 writing 0 keeps flag", v[2], 1);
    wr(5, 8'h04);
    rd(5, v);
    check("R10 writing 1 clears match B flag", v[2], 0);
    check("R10 other flag untouched", v[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_ctc_toggle();
    t_missed();
    t_pwm_fixed();
    t_pwm_top_a();
    t_block();
    t_flags();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule